// File: doc/BRIEF.md
# VCO Sub-Band Successive-Approximation Calibrator

This block chooses one of 64 oscillator sub-bands so that the loop's tuning voltage ends up inside a window bounded by a low and a high threshold. Two external comparators report whether the voltage sits above the upper threshold or below the lower one. Each search is a six-step successive approximation that always starts from the middle code, 31. At every step the code moves by a halving amount, or stays where it is when the voltage is already inside the window.

The search advances on a slow calibration tick. This tick is derived from the reference clock through a divider whose ratio is a power of two between 512 and 65536. A search is armed from the serial configuration side: a falling edge of the interface enable starts it, but only while the start bit is set. After a search ends, the block keeps watching the comparators and starts again on its own when the voltage leaves the window. A polarity input reverses which comparator means "step up", so the block can serve tanks with either tuning-gain sign.

The chosen band is driven out as a 64-bit thermometer word. A manual select replaces that word with a word supplied by software, while the automatic search goes on underneath.

Top module: `vco_band_cal`

## Requirements
- R1: After synchronous reset the band code is 31, busy and done are 0, and the thermometer output has bits 0 to 31 set and bits 32 to 63 clear.
- R2: A falling edge of `cfg_en` while `cal_arm` is 1 starts a search at the next calibration tick. At that tick busy rises and the band code is 31.
- R3: A falling edge of `cfg_en` while `cal_arm` is 0, and any rising edge of `cfg_en`, start nothing: busy stays 0 and the code is unchanged.
- R4: A search takes exactly six calibration ticks after its start tick. It then lowers busy and raises done, and it leaves the code at the band where neither comparator is active.
- R5: With `dir_pol` = 0, an active `above_hi` raises the code by the current step and an active `below_lo` lowers it. The steps are 16, 8, 4, 2, 1, 1 and the code saturates at 0 and 63.
- R6: With `dir_pol` = 1 the roles swap: an active `below_lo` raises the code and an active `above_hi` lowers it.
- R7: In a search step where both flags are inactive, or both are active, the code is held and the search still moves on to the next smaller step.
- R8: While done is 1, a calibration tick that sees either synchronized flag active starts a new search from code 31 without any command.
- R9: The calibration tick period is 512 × 2^`div_sel` reference-clock cycles (`div_sel` 0 to 7).
- R10: When `man_sel` is 0, `band_therm` bit i is 1 exactly when i ≤ band code. This output is registered one cycle after the code.
- R11: When `man_sel` is 1, `band_therm` equals `man_word` one cycle later, and the automatic search still runs and ends on the right band code.
- R12: The band code changes only on a calibration tick, so it is stable while the block sits idle inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Calibration tick divider select |
| cfg_en | input | 1 | Serial interface enable; its falling edge is the start trigger |
| cal_arm | input | 1 | Start-calibration bit that qualifies the trigger |
| dir_pol | input | 1 | Search direction polarity |
| above_hi | input | 1 | Asynchronous flag: tuning voltage above the high threshold |
| below_lo | input | 1 | Asynchronous flag: tuning voltage below the low threshold |
| man_sel | input | 1 | Selects the manual band word |
| man_word | input | 64 | Manual thermometer band word |
| band_code | output | 6 | Current band code |
| band_therm | output | 64 | Thermometer-coded band driven to the tank |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished; monitoring the window |

## Verification
Two events can land on the same calibration tick while the block is locked: a start command arriving from the serial side, and a window excursion from a comparator. The bench provokes this by moving its modelled target band and dropping the armed enable on the same clock. It then judges the outcome in three ways. Busy must rise exactly once before done returns, the code must read 31 when busy rises, and the single search must end on the new target. A second overlap is the manual override held during a full search: the output word must stay fixed while the code still converges underneath.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_t;
endpackage

// File: rtl/cal_tick_div.sv
module cal_tick_div #(
  parameter int BASE_LOG2 = 9,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             wrap;

  always_comb begin
    limit = (CNT_W'(1) << (BASE_LOG2 + int'(div_sel))) - CNT_W'(1);
    wrap  = (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= wrap ? '0 : cnt + CNT_W'(1);
      tick <= wrap;
    end
  end

  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/cal_flag_sync.sv
module cal_flag_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cal_sar_core.sv
module cal_sar_core
  import cal_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_req,
  input  logic              pol,
  input  logic              flag_hi,
  input  logic              flag_lo,
  output logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W = $clog2(CODE_W);
  localparam int LAST  = CODE_W - 1;
  localparam logic [CODE_W-1:0] MID = CODE_W'((1 << (CODE_W - 1)) - 1);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  logic              pend;
  logic [IDX_W-1:0]  idx;
  step_dir_t         dir;
  logic [CODE_W-1:0] step;
  logic [CODE_W:0]   up_sum;
  logic [CODE_W-1:0] next_code;
  logic              go;

  always_comb begin
    if (flag_hi == flag_lo)             dir = DIR_HOLD;
    else if (pol ? flag_lo : flag_hi)   dir = DIR_UP;
    else                                dir = DIR_DOWN;

    if (idx < IDX_W'(LAST)) step = CODE_W'(1) << (LAST - 1 - int'(idx));
    else                    step = CODE_W'(1);

    up_sum = {1'b0, code} + {1'b0, step};
    case (dir)
      DIR_UP:   next_code = up_sum[CODE_W] ? TOP : up_sum[CODE_W-1:0];
      DIR_DOWN: next_code = (code < step) ? '0 : code - step;
      default:  next_code = code;
    endcase

    go = tick & (pend | start_req | (done & (flag_hi | flag_lo)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= MID;
      busy <= 1'b0;
      done <= 1'b0;
      pend <= 1'b0;
      idx  <= '0;
    end else begin
      pend <= tick ? 1'b0 : (pend | start_req);
      if (go) begin
        code <= MID;
        busy <= 1'b1;
        done <= 1'b0;
        idx  <= '0;
      end else if (tick && busy) begin
        code <= next_code;
        if (idx == IDX_W'(LAST)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R4
  search_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R2
  start_mid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (code == MID));
  // R12
  code_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(code));
  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx <= IDX_W'(LAST)));
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
  parameter int CODE_W        = 6,
  parameter int DIV_BASE_LOG2 = 9,
  parameter int DIV_SEL_W     = 3,
  parameter int SYNC_STAGES   = 2,
  localparam int BANDS        = 1 << CODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 cfg_en,
  input  logic                 cal_arm,
  input  logic                 dir_pol,
  input  logic                 above_hi,
  input  logic                 below_lo,
  input  logic                 man_sel,
  input  logic [BANDS-1:0]     man_word,
  output logic [CODE_W-1:0]    band_code,
  output logic [BANDS-1:0]     band_therm,
  output logic                 busy,
  output logic                 done
);
  logic             tick;
  logic             en_q;
  logic             start_req;
  logic [1:0]       flags_s;
  logic [BANDS-1:0] auto_therm;

  cal_tick_div #(.BASE_LOG2(DIV_BASE_LOG2), .SEL_W(DIV_SEL_W)) i_div (
    .clk(clk), .rst(rst), .div_sel(div_sel), .tick(tick)
  );

  cal_flag_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d_async({above_hi, below_lo}), .q_sync(flags_s)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= cfg_en;
  end

  assign start_req = en_q & ~cfg_en & cal_arm;

  cal_sar_core #(.CODE_W(CODE_W)) i_core (
    .clk(clk), .rst(rst), .tick(tick), .start_req(start_req), .pol(dir_pol),
    .flag_hi(flags_s[1]), .flag_lo(flags_s[0]),
    .code(band_code), .busy(busy), .done(done)
  );

  for (genvar i = 0; i < BANDS; i++) begin : g_therm
    assign auto_therm[i] = (CODE_W'(i) <= band_code);
  end

  always_ff @(posedge clk) begin
    if (rst) band_therm <= BANDS'((BANDS'(1) << (BANDS / 2)) - BANDS'(1));
    else     band_therm <= man_sel ? man_word : auto_therm;
  end

  // R11
  manual_pass_chk: assert property (@(posedge clk) disable iff (rst)
    man_sel |=> (band_therm == $past(man_word)));
  // R10
  auto_floor_chk: assert property (@(posedge clk) disable iff (rst)
    !man_sel |=> band_therm[0]);
endmodule

// File: tb/test_vco_band_cal.sv
module test_vco_band_cal;
  localparam int NB = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic cfg_en = 1'b0, cal_arm = 1'b0, dir_pol = 1'b0;
  logic above_hi, below_lo;
  logic man_sel = 1'b0;
  logic [NB-1:0] man_word = '0;
  logic [5:0] band_code;
  logic [NB-1:0] band_therm;
  logic busy, done;

  int tgt = 31;
  logic frc = 1'b0, frc_hi = 1'b0, frc_lo = 1'b0;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  always_comb begin
    logic need_up, need_dn;
    need_up = int'(band_code) < tgt;
    need_dn = int'(band_code) > tgt;
    above_hi = frc ? frc_hi : (dir_pol ? need_dn : need_up);
    below_lo = frc ? frc_lo : (dir_pol ? need_up : need_dn);
  end

  vco_band_cal i_vco_band_cal (
    .clk(clk), .rst(rst), .div_sel(div_sel), .cfg_en(cfg_en), .cal_arm(cal_arm),
    .dir_pol(dir_pol), .above_hi(above_hi), .below_lo(below_lo),
    .man_sel(man_sel), .man_word(man_word), .band_code(band_code),
    .band_therm(band_therm), .busy(busy), .done(done)
  );

  function automatic logic [NB-1:0] therm_of(input int c);
    logic [NB-1:0] t;
    for (int i = 0; i < NB; i++) t[i] = (i <= c);
    return t;
  endfunction

  function automatic int period();
    return 512 << div_sel;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int t_fall;
  task automatic fire(input bit arm);
    @(negedge clk); cfg_en = 1'b1; cal_arm = arm;
    repeat (2) @(negedge clk);
    cfg_en = 1'b0; t_fall = cyc;
    repeat (2) @(negedge clk);
    cal_arm = 1'b0;
  endtask

  task automatic wait_search(output bit ok, output int dur, output int rises,
                             output int first_code);
    int t0 = cyc;
    bit seen = 1'b0;
    bit prev = busy;
    rises = 0; first_code = -1; ok = 1'b0;
    while (cyc - t0 < 8 * period() + 40) begin
      @(negedge clk);
      if (busy && !prev) begin
        rises++;
        if (first_code < 0) first_code = int'(band_code);
      end
      prev = busy;
      if (busy) seen = 1'b1;
      if (seen && done && !busy) begin ok = 1'b1; break; end
    end
    dur = cyc - t_fall;
  endtask

  task automatic idle_watch(input int n, output int rises, output int code_end);
    rises = 0;
    repeat (n) begin
      @(negedge clk);
      if (busy) rises++;
    end
    code_end = int'(band_code);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(band_code == 6'd31, "R1", "reset code", NB'(band_code), NB'(31));
    chk(!busy && !done, "R1", "reset busy/done", NB'({busy, done}), NB'(0));
    chk(band_therm == therm_of(31), "R1", "reset therm", band_therm, therm_of(31));
  endtask

  task automatic t_search(input bit pol, input int target, input string req);
    bit ok; int dur, rises, fc;
    dir_pol = pol; tgt = target;
    fire(1'b1);
    wait_search(ok, dur, rises, fc);
    chk(ok, "R4", "search completes", NB'(ok), NB'(1));
    chk(fc == 31, "R2", "code at start", NB'(fc), NB'(31));
    chk(band_code == 6'(target), req, "final code", NB'(band_code), NB'(target));
    chk(dur > 6 * period() && dur <= 7 * period() + 4, "R9", "search duration",
        NB'(dur), NB'(7 * period()));
    repeat (2) @(negedge clk);
    chk(band_therm == therm_of(target), "R10", "therm of code", band_therm, therm_of(target));
  endtask

  task automatic t_idle_and_ignore();
    int r, c;
    int keep = int'(band_code);
    idle_watch(3 * period(), r, c);
    chk(r == 0 && c == keep, "R12", "code stable when idle", NB'(c), NB'(keep));
    fire(1'b0);
    idle_watch(3 * period(), r, c);
    chk(r == 0 && c == keep, "R3", "unarmed fall ignored", NB'(r), NB'(0));
    @(negedge clk); cal_arm = 1'b1; cfg_en = 1'b1;
    idle_watch(3 * period(), r, c);
    cal_arm = 1'b0;
    chk(r == 0 && c == keep, "R3", "rising edge ignored", NB'(r), NB'(0));
  endtask

  task automatic t_flags_both(input bit lvl);
    bit ok; int dur, rises, fc;
    frc = 1'b1; frc_hi = lvl; frc_lo = lvl;
    fire(1'b1);
    wait_search(ok, dur, rises, fc);
    chk(ok && band_code == 6'd31, "R7", lvl ? "both flags hold" : "no flags hold",
        NB'(band_code), NB'(31));
    chk(dur > 6 * period(), "R7", "all steps taken", NB'(dur), NB'(6 * period()));
    @(negedge clk);
    tgt = 31; frc = 1'b0; frc_hi = 1'b0; frc_lo = 1'b0;
    repeat (9 * period()) @(negedge clk);
  endtask

  task automatic t_drift(input int target);
    bit ok; int dur, rises, fc;
    @(negedge clk); tgt = target; t_fall = cyc;
    wait_search(ok, dur, rises, fc);
    chk(ok && fc == 31, "R8", "auto restart from mid", NB'(fc), NB'(31));
    chk(band_code == 6'(target), "R8", "re-search result", NB'(band_code), NB'(target));
  endtask

  task automatic t_manual();
    bit ok; int dur, rises, fc;
    bit held = 1'b1;
    logic [NB-1:0] w = 64'hF0E1_D2C3_B4A5_9687;
    @(negedge clk); man_sel = 1'b1; man_word = w;
    repeat (2) @(negedge clk);
    chk(band_therm == w, "R11", "manual word out", band_therm, w);
    tgt = 20; t_fall = cyc;
    fork
      wait_search(ok, dur, rises, fc);
      while (!ok) begin @(negedge clk); if (band_therm != w) held = 1'b0; end
    join
    chk(held, "R11", "manual held during search", NB'(held), NB'(1));
    chk(band_code == 6'd20, "R11", "search under manual", NB'(band_code), NB'(20));
    @(negedge clk); man_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk(band_therm == therm_of(20), "R10", "back to auto", band_therm, therm_of(20));
  endtask

  task automatic t_coincide();
    bit ok; int dur, rises, fc;
    @(negedge clk); cfg_en = 1'b1; cal_arm = 1'b1;
    repeat (2) @(negedge clk);
    tgt = 12; cfg_en = 1'b0; t_fall = cyc;
    wait_search(ok, dur, rises, fc);
    cal_arm = 1'b0;
    chk(ok && rises == 1, "R8", "single search on overlap", NB'(rises), NB'(1));
    chk(fc == 31, "R2", "overlap starts mid", NB'(fc), NB'(31));
    chk(band_code == 6'd12, "R4", "overlap result", NB'(band_code), NB'(12));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_search(1'b0, 50, "R5");
    t_idle_and_ignore();
    t_search(1'b1, 10, "R6");
    t_drift(45);
    t_search(1'b0, 0, "R5");
    t_search(1'b1, 63, "R6");
    t_flags_both(1'b0);
    t_flags_both(1'b1);
    t_manual();
    div_sel = 3'd1;
    t_search(1'b0, 33, "R9");
    t_coincide();
    finish_run();
  end
endmodule